// File: doc/BRIEF.md
# Core and Package Idle-State Resolver

This block merges the idle-state requests of every hardware thread into one idle state per core, and then merges the core states into a single package idle state. Each core settles on the shallowest state that any of its threads asks for. An optional promotion reports cores at C1 as C1E once every active core is idle. When every active core is deep, execution-allowed status drops. The package then asks the platform for permission to go deeper, through a request/grant pair.

A package state machine follows these conditions. Its states are RUN (package C0), IDLE (package C1), FREQ (package C1E, frequency lowered), VOLT (package C1E, frequency and voltage lowered), REQ (package C3 with the request raised), DEEP3 (package C3 granted) and DEEP6 (package C6 granted).

Its transitions are as follows:
- wake: any state goes to RUN.
- settle: RUN goes to IDLE.
- promote: IDLE goes to FREQ, and FREQ goes to VOLT.
- deepen: IDLE, FREQ or VOLT goes to REQ.
- grant: REQ goes to DEEP3 or DEEP6.
- upgrade: DEEP3 goes back to REQ.
- shallow: REQ, DEEP3 or DEEP6 goes to IDLE.
- downgrade: DEEP6 goes to DEEP3.
- c1e-off: FREQ or VOLT goes to IDLE.

Clock and voltage control, deep-entry delay timers and links to other sockets lie outside the block.

Top module: `idle_state_resolver`

## Requirements
- R1: Idle states are 3-bit codes: 0 = C0, 1 = C1, 2 = C1E, 3 = C3, 6 = C6, 7 = C7. A thread request of 4 or 5 is treated as C1. Each core output `core_state_o[3c+2:3c]` shows the lowest code among its threads, one cycle after the inputs.
- R2: When `c1e_en_i` is 1, at least one core is active, and no active core has a thread at C0, every core that resolves to C1 is reported as C1E (2).
- R3: A core whose `core_active_i` bit is 0 is left out of every all-active-cores condition. A C0 request on such a core neither wakes the package nor blocks deep states.
- R4: `exec_allowed_o` is 0 exactly when at least one core is active and every active core resolves to C3 or deeper. It updates one cycle after the inputs and resets to 1.
- R5: `pkg_req_o` is 1 only in REQ. REQ is entered from IDLE, FREQ or VOLT when every active core is deep, and reports package C3.
- R6: `plat_grant_i` is acted on only in REQ. Seeing the grant, or losing the all-deep condition, makes `pkg_req_o` fall on the next cycle.
- R7: A grant leads to DEEP6 (package code 6) only if at least one active core is at C6 or C7. Otherwise it leads to DEEP3 (code 3). DEEP3 re-requests through REQ once that C6 condition appears. DEEP6 falls to DEEP3 when the condition is lost.
- R8: The package code is never 7. A core at C7 counts as C6 for the package.
- R9: With C1E enabled, IDLE moves to FREQ (`freq_low_o`=1, code 2) and then to VOLT (`freq_low_o`=1, `volt_low_o`=1). The voltage is never lowered before the frequency. Clearing `c1e_en_i` returns to IDLE.
- R10: A C0 request from any thread of an active core, or no core being active, returns the package to RUN (code 0, request withdrawn) on the next cycle.
- R11: After reset, all core states and the package code are 0, `exec_allowed_o` is 1, and `pkg_req_o`, `freq_low_o` and `volt_low_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| thread_req_i | input | NUM_CORES*THREADS*3 | Per-thread idle request; thread t of core c at bits (c*THREADS+t)*3 +: 3 |
| core_active_i | input | NUM_CORES | Per-core active flag |
| c1e_en_i | input | 1 | C1E promotion enable |
| plat_grant_i | input | 1 | Platform permission for a deep package state |
| core_state_o | output | NUM_CORES*3 | Resolved state of each core |
| pkg_state_o | output | 3 | Resolved package state code |
| exec_allowed_o | output | 1 | 0 when all active cores are deep |
| pkg_req_o | output | 1 | Request for a coordinated package state |
| freq_low_o | output | 1 | Lowest core frequency requested |
| volt_low_o | output | 1 | Voltage reduction requested |

## Verification
Every output is registered once, so each result is due exactly one clock edge after the inputs that cause it. This holds for core states, execution-allowed status and all package signals. Multi-step effects, such as the C1E frequency-then-voltage order or a grant following a request, appear one edge per state transition. The bench drives inputs just after a rising edge and predicts the outputs for the next edge from its own model. It compares them one time unit after that edge, so every compare lines up with the single register stage.

// File: rtl/idle_res_pkg.sv
package idle_res_pkg;

    localparam int ST_W = 3;

    localparam logic [ST_W-1:0] CS_C0  = 3'd0;
    localparam logic [ST_W-1:0] CS_C1  = 3'd1;
    localparam logic [ST_W-1:0] CS_C1E = 3'd2;
    localparam logic [ST_W-1:0] CS_C3  = 3'd3;
    localparam logic [ST_W-1:0] CS_C6  = 3'd6;
    localparam logic [ST_W-1:0] CS_C7  = 3'd7;

    typedef enum logic [2:0] {
        PK_RUN   = 3'd0,
        PK_IDLE  = 3'd1,
        PK_FREQ  = 3'd2,
        PK_VOLT  = 3'd3,
        PK_REQ   = 3'd4,
        PK_DEEP3 = 3'd5,
        PK_DEEP6 = 3'd6
    } pkg_fsm_e;

    // Map unsupported request codes onto C1.
    function automatic logic [ST_W-1:0] norm_req(input logic [ST_W-1:0] r);
        unique case (r)
            CS_C0, CS_C1, CS_C1E, CS_C3, CS_C6, CS_C7: return r;
            default:                                   return CS_C1;
        endcase
    endfunction

endpackage

// File: rtl/idle_core_resolve.sv
module idle_core_resolve
    import idle_res_pkg::*;
#(
    parameter int THREADS = 2
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [THREADS*ST_W-1:0] thr_req_i,
    input  logic                    promote_i,
    output logic [ST_W-1:0]         raw_min_o,
    output logic [ST_W-1:0]         state_o
);

    logic [ST_W-1:0] min_v;
    logic [ST_W-1:0] state_q;

    // Shallowest request among the threads of this core.
    always_comb begin
        logic [ST_W-1:0] v;
        min_v = CS_C7;
        for (int t = 0; t < THREADS; t++) begin
            v = norm_req(thr_req_i[t*ST_W +: ST_W]);
            if (v < min_v) min_v = v;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                              state_q <= CS_C0;
        else if (promote_i && (min_v == CS_C1))   state_q <= CS_C1E;
        else                                      state_q <= min_v;
    end

    assign raw_min_o = min_v;
    assign state_o   = state_q;

    // R1: output is the shallowest request, or its C1E promotion.
    assert_core_shallowest_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (state_o == $past(min_v)) ||
                 (($past(min_v) == CS_C1) && (state_o == CS_C1E)));

    // R2: no promotion to C1E without the promote condition.
    assert_no_stray_c1e_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!promote_i && (min_v != CS_C1E)) |=> (state_o != CS_C1E));

endmodule

// File: rtl/idle_pkg_fsm.sv
module idle_pkg_fsm
    import idle_res_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            wake_i,
    input  logic            all_deep_i,
    input  logic            c6_ok_i,
    input  logic            c1e_en_i,
    input  logic            grant_i,
    output logic [ST_W-1:0] pkg_state_o,
    output logic            pkg_req_o,
    output logic            freq_low_o,
    output logic            volt_low_o
);

    pkg_fsm_e state_q, state_d;

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= PK_RUN;
        else         state_q <= state_d;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (wake_i) begin
            state_d = PK_RUN;
        end else begin
            unique case (state_q)
                PK_RUN:   state_d = PK_IDLE;
                PK_IDLE: begin
                    if (all_deep_i)    state_d = PK_REQ;
                    else if (c1e_en_i) state_d = PK_FREQ;
                end
                PK_FREQ: begin
                    if (all_deep_i)     state_d = PK_REQ;
                    else if (!c1e_en_i) state_d = PK_IDLE;
                    else                state_d = PK_VOLT;
                end
                PK_VOLT: begin
                    if (all_deep_i)     state_d = PK_REQ;
                    else if (!c1e_en_i) state_d = PK_IDLE;
                end
                PK_REQ: begin
                    if (!all_deep_i)  state_d = PK_IDLE;
                    else if (grant_i) state_d = c6_ok_i ? PK_DEEP6 : PK_DEEP3;
                end
                PK_DEEP3: begin
                    if (!all_deep_i)  state_d = PK_IDLE;
                    else if (c6_ok_i) state_d = PK_REQ;
                end
                PK_DEEP6: begin
                    if (!all_deep_i)   state_d = PK_IDLE;
                    else if (!c6_ok_i) state_d = PK_DEEP3;
                end
                default: state_d = PK_RUN;
            endcase
        end
    end

    // Output decode.
    always_comb begin
        pkg_state_o = CS_C0;
        pkg_req_o   = 1'b0;
        freq_low_o  = 1'b0;
        volt_low_o  = 1'b0;
        unique case (state_q)
            PK_RUN:   pkg_state_o = CS_C0;
            PK_IDLE:  pkg_state_o = CS_C1;
            PK_FREQ: begin
                pkg_state_o = CS_C1E;
                freq_low_o  = 1'b1;
            end
            PK_VOLT: begin
                pkg_state_o = CS_C1E;
                freq_low_o  = 1'b1;
                volt_low_o  = 1'b1;
            end
            PK_REQ: begin
                pkg_state_o = CS_C3;
                pkg_req_o   = 1'b1;
            end
            PK_DEEP3: pkg_state_o = CS_C3;
            PK_DEEP6: pkg_state_o = CS_C6;
            default:  pkg_state_o = CS_C0;
        endcase
    end

    assert_no_pkg_c7_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pkg_state_o != CS_C7);

    assert_req_drops_after_grant_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pkg_req_o && grant_i) |=> !pkg_req_o);

    assert_c6_needs_grant_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pkg_state_o == CS_C6) |-> $past(pkg_req_o && grant_i && c6_ok_i));

    assert_volt_after_freq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(volt_low_o) |-> $past(freq_low_o));

    assert_wake_to_c0_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_i |=> (pkg_state_o == CS_C0) && !pkg_req_o);

endmodule

// File: rtl/idle_state_resolver.sv
module idle_state_resolver
    import idle_res_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int THREADS   = 2
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic [NUM_CORES*THREADS*ST_W-1:0] thread_req_i,
    input  logic [NUM_CORES-1:0]              core_active_i,
    input  logic                              c1e_en_i,
    input  logic                              plat_grant_i,
    output logic [NUM_CORES*ST_W-1:0]         core_state_o,
    output logic [ST_W-1:0]                   pkg_state_o,
    output logic                              exec_allowed_o,
    output logic                              pkg_req_o,
    output logic                              freq_low_o,
    output logic                              volt_low_o
);

    localparam int CORE_W = THREADS * ST_W;

    logic [ST_W-1:0] raw_min [NUM_CORES];
    logic any_active, any_c0, all_deep, any_c6, c6_ok, wake, promote;
    logic exec_q;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        idle_core_resolve #(.THREADS(THREADS)) u_core (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .thr_req_i (thread_req_i[c*CORE_W +: CORE_W]),
            .promote_i (promote),
            .raw_min_o (raw_min[c]),
            .state_o   (core_state_o[c*ST_W +: ST_W])
        );
    end

    // Conditions over the active cores only.
    always_comb begin
        any_active = 1'b0;
        any_c0     = 1'b0;
        all_deep   = 1'b1;
        any_c6     = 1'b0;
        for (int c = 0; c < NUM_CORES; c++) begin
            if (core_active_i[c]) begin
                any_active = 1'b1;
                if (raw_min[c] == CS_C0) any_c0   = 1'b1;
                if (raw_min[c] <  CS_C3) all_deep = 1'b0;
                if (raw_min[c] >= CS_C6) any_c6   = 1'b1;
            end
        end
        all_deep = all_deep && any_active;
        c6_ok    = all_deep && any_c6;
        wake     = any_c0 || !any_active;
        promote  = c1e_en_i && !wake;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) exec_q <= 1'b1;
        else         exec_q <= !all_deep;
    end
    assign exec_allowed_o = exec_q;

    idle_pkg_fsm u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wake_i      (wake),
        .all_deep_i  (all_deep),
        .c6_ok_i     (c6_ok),
        .c1e_en_i    (c1e_en_i),
        .grant_i     (plat_grant_i),
        .pkg_state_o (pkg_state_o),
        .pkg_req_o   (pkg_req_o),
        .freq_low_o  (freq_low_o),
        .volt_low_o  (volt_low_o)
    );

    // R4: execution held off only while every active core is deep.
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
        assert_exec_low_deep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!exec_allowed_o && $past(core_active_i[c])) |->
                (core_state_o[c*ST_W +: ST_W] >= CS_C3));
    end

    // R5: the request only stands while execution is not allowed.
    assert_req_implies_deep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pkg_req_o |-> !exec_allowed_o);

endmodule

// File: tb/idle_state_resolver_tb.sv
module idle_state_resolver_tb;

    localparam int NC = 4;
    localparam int NT = 2;

    // Bench model states.
    localparam int M_RUN = 0, M_IDLE = 1, M_FREQ = 2, M_VOLT = 3,
                   M_REQ = 4, M_D3 = 5, M_D6 = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NC*NT*3-1:0] treq = '0;
    logic [NC-1:0]      act  = '1;
    logic               c1e  = 1'b0;
    logic               gnt  = 1'b0;

    logic [NC*3-1:0] core_st;
    logic [2:0]      pkg_st;
    logic            exec_al, preq, flow, vlow;

    int n_chk = 0;
    int n_bad = 0;
    int ms    = M_RUN;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    idle_state_resolver #(.NUM_CORES(NC), .THREADS(NT)) u_dut (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .thread_req_i   (treq),
        .core_active_i  (act),
        .c1e_en_i       (c1e),
        .plat_grant_i   (gnt),
        .core_state_o   (core_st),
        .pkg_state_o    (pkg_st),
        .exec_allowed_o (exec_al),
        .pkg_req_o      (preq),
        .freq_low_o     (flow),
        .volt_low_o     (vlow)
    );

    function automatic int nrm(input logic [2:0] v);
        if (v == 3'd4 || v == 3'd5) return 1;
        return int'(v);
    endfunction

    function automatic int pkg_code(input int s);
        case (s)
            M_RUN:        return 0;
            M_IDLE:       return 1;
            M_FREQ, M_VOLT: return 2;
            M_REQ, M_D3:  return 3;
            default:      return 6;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input int a, input int e);
        n_chk++;
        if (a != e) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, a, e, $time);
        end
    endtask

    task automatic set_core(input int c, input int a, input int b);
        treq[(c*NT)*3 +: 3]   = 3'(a);
        treq[(c*NT+1)*3 +: 3] = 3'(b);
    endtask

    // Predict, advance one edge, compare.
    task automatic step(input string tag);
        int rmin [NC];
        bit any_a, any_z, deep, c6, wk, prom;
        int nx;
        any_a = 0; any_z = 0; deep = 1; c6 = 0;
        for (int c = 0; c < NC; c++) begin
            rmin[c] = 7;
            for (int t = 0; t < NT; t++)
                if (nrm(treq[(c*NT+t)*3 +: 3]) < rmin[c]) rmin[c] = nrm(treq[(c*NT+t)*3 +: 3]);
            if (act[c]) begin
                any_a = 1;
                if (rmin[c] == 0) any_z = 1;
                if (rmin[c] < 3)  deep = 0;
                if (rmin[c] >= 6) c6 = 1;
            end
        end
        deep = deep && any_a;
        c6   = c6 && deep;
        wk   = any_z || !any_a;
        prom = c1e && !wk;
        nx = ms;
        if (wk) nx = M_RUN;
        else case (ms)
            M_RUN:  nx = M_IDLE;
            M_IDLE: nx = deep ? M_REQ : (c1e ? M_FREQ : M_IDLE);
            M_FREQ: nx = deep ? M_REQ : (!c1e ? M_IDLE : M_VOLT);
            M_VOLT: nx = deep ? M_REQ : (!c1e ? M_IDLE : M_VOLT);
            M_REQ:  nx = !deep ? M_IDLE : (gnt ? (c6 ? M_D6 : M_D3) : M_REQ);
            M_D3:   nx = !deep ? M_IDLE : (c6 ? M_REQ : M_D3);
            default: nx = !deep ? M_IDLE : (!c6 ? M_D3 : M_D6);
        endcase
        @(posedge clk);
        #1;
        for (int c = 0; c < NC; c++)
            chk(tag == "" ? "R1" : tag, $sformatf("core%0d", c),
                int'(core_st[c*3 +: 3]), (prom && rmin[c] == 1) ? 2 : rmin[c]);
        chk(tag == "" ? "R4" : tag, "exec_allowed", int'(exec_al), int'(!deep));
        chk(tag == "" ? "R5" : tag, "pkg_req", int'(preq), int'(nx == M_REQ));
        chk(tag == "" ? "R7" : tag, "pkg_state", int'(pkg_st), pkg_code(nx));
        chk(tag == "" ? "R9" : tag, "freq_low", int'(flow), int'(nx == M_FREQ || nx == M_VOLT));
        chk(tag == "" ? "R9" : tag, "volt_low", int'(vlow), int'(nx == M_VOLT));
        ms = nx;
    endtask

    task automatic all_cores(input int a, input int b);
        for (int c = 0; c < NC; c++) set_core(c, a, b);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20251));
        repeat (3) @(posedge clk);
        #1;
        // R11: reset values
        chk("R11", "core_state", int'(core_st), 0);
        chk("R11", "pkg_state", int'(pkg_st), 0);
        chk("R11", "exec_allowed", int'(exec_al), 1);
        chk("R11", "req/freq/volt", int'({preq, flow, vlow}), 0);
        rst_n = 1'b1;

        // R1: shallowest thread wins, codes 4/5 read as C1
        all_cores(3, 3);
        set_core(0, 2, 3);
        set_core(1, 4, 6);
        set_core(2, 5, 7);
        step("R1");
        step("R1");

        // R2: C1E promotion when all active cores idle
        c1e = 1'b1;
        all_cores(3, 3);
        set_core(0, 1, 1);
        step("R2");
        step("R2");
        step("R9");
        step("R9");
        c1e = 1'b0;
        step("R9");

        // R10: one thread back to C0 wakes the package
        set_core(2, 0, 3);
        step("R10");
        step("R10");

        // R3: inactive core at C0 does not block deep states
        all_cores(6, 6);
        set_core(3, 0, 0);
        act = 4'b0111;
        gnt = 1'b1;
        step("R3");
        step("R3");
        step("R6");
        step("R6");
        step("R7");

        // R7: loss of C6 drops to package C3, regain re-requests
        all_cores(3, 3);
        step("R7");
        all_cores(7, 7);
        gnt = 1'b0;
        step("R7");
        step("R6");
        step("R6");
        gnt = 1'b1;
        // R8: cores at C7 give package C6, never C7
        step("R8");
        step("R8");

        // R6: grant outside a request has no effect
        all_cores(1, 1);
        step("R6");
        step("R6");
        gnt = 1'b0;
        all_cores(3, 6);
        step("R5");
        step("R5");
        all_cores(1, 3);
        step("R6");

        // R10: no active core acts as a wake
        act = '0;
        step("R10");
        act = '1;

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            if ($urandom % 3 == 0) begin
                for (int k = 0; k < NC*NT; k++) begin
                    int v;
                    v = int'($urandom % 8);
                    if (v == 0 && ($urandom % 6 != 0)) v = 3;
                    treq[k*3 +: 3] = 3'(v);
                end
                for (int c = 0; c < NC; c++) act[c] = ($urandom % 8 != 0);
                c1e = ($urandom % 4 != 0);
            end
            gnt = ($urandom % 2 == 0);
            step("");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule